// File: doc/BRIEF.md
# Branch Resolve Flush and Accuracy Unit

This unit sits in the execute stage of a pipelined core. It takes each control-transfer instruction once its outcome is known. It compares the address the fetch stage actually chose to follow that instruction with the address that should have followed it. When the two differ, it requests a pipeline flush in the same cycle. For every valid instruction it also drives the update strobes back to the fetch-stage predictor: a shift of the global history, a training write for the two-bit pattern table and a write into the target buffer.

Two free-running performance counters support accuracy measurement. One counts every resolved control transfer, with unconditional jumps included. The other counts those that needed no flush. Accuracy is the second count divided by the first. Target computation and the predictor tables themselves are supplied by neighbouring blocks. The pattern-table index formed in fetch is carried in with the instruction and is returned unchanged.

Top module: `brf_unit`

## Requirements
- R1: When a valid instruction resolves taken (a jump is always taken, whatever `ex_taken` says) and `ex_pred_next` differs from `ex_target`, `flush` is 1 in that same cycle.
- R2: When a valid conditional branch resolves not taken and `ex_pred_next` differs from `ex_pc + 4`, `flush` is 1 in that same cycle.
- R3: When `ex_pred_next` equals the actual next address (the target if taken, otherwise `ex_pc + 4`), `flush` is 0, including the case where the target equals `ex_pc + 4`.
- R4: When `ex_valid` is 0, `flush` and all update enables are 0, and neither counter changes on the next edge.
- R5: `perf_total` increases by exactly 1 on the clock edge that ends each cycle in which `ex_valid` is 1.
- R6: `perf_correct` increases by exactly 1 on that edge when the valid instruction raised no flush, and is otherwise unchanged.
- R7: A jump (`ex_jump`=1) counts in both counters. It produces no pattern-table update and no history update.
- R8: Every valid instruction, taken or not, asserts `btb_upd_en`, with `btb_upd_pc`=`ex_pc` and `btb_upd_target`=`ex_target`.
- R9: A valid conditional branch asserts `pht_upd_en`, with `pht_upd_idx`=`ex_hist_idx` and `pht_upd_taken`=`ex_taken`. It also asserts `hist_upd_en`, with `hist_upd_bit`=`ex_taken`.
- R10: Both counters are `CNT_W` (32) bits wide and read 0 after an active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | A control-transfer instruction resolves this cycle |
| ex_jump | input | 1 | The instruction is an unconditional jump |
| ex_taken | input | 1 | Resolved outcome of a conditional branch |
| ex_target | input | ADDR_W | Computed target address |
| ex_pc | input | ADDR_W | Address of the instruction |
| ex_pred_next | input | ADDR_W | Address fetched after it |
| ex_hist_idx | input | IDX_W | Pattern-table index used at fetch |
| flush | output | 1 | Flush request, same cycle |
| hist_upd_en | output | 1 | Shift the global history |
| hist_upd_bit | output | 1 | Bit shifted into the history |
| pht_upd_en | output | 1 | Train a pattern-table counter |
| pht_upd_idx | output | IDX_W | Index of the counter to train |
| pht_upd_taken | output | 1 | Training direction |
| btb_upd_en | output | 1 | Write the target buffer |
| btb_upd_pc | output | ADDR_W | Instruction address for the buffer write |
| btb_upd_target | output | ADDR_W | Target stored in the buffer |
| perf_total | output | CNT_W | Resolved control transfers |
| perf_correct | output | CNT_W | Transfers resolved without flush |

## Verification
The flush request and every update strobe are combinational, so they are due in the cycle the stimulus is applied. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. Counter results are due one edge later. They are compared at the start of the following falling-edge slot, against running totals kept in the bench. The sweep covers valid and invalid slots, jumps and branches, both outcomes, three kinds of predicted address, and the case where target and fall-through coincide.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic [1:0] {
    RES_IDLE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2
  } res_kind_e;

  localparam int unsigned INSN_BYTES = 4;
  localparam int unsigned N_CNT      = 2;
  localparam int unsigned CNT_TOTAL  = 0;
  localparam int unsigned CNT_GOOD   = 1;
endpackage

// File: rtl/brf_resolve.sv
module brf_resolve
  import brf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              valid,
  input  logic              jump,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] pred_next,
  output logic              eff_taken,
  output logic [ADDR_W-1:0] actual_next,
  output res_kind_e         kind
);
  function automatic logic [ADDR_W-1:0] seq_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(INSN_BYTES);
  endfunction

  function automatic res_kind_e classify(input logic v,
                                         input logic [ADDR_W-1:0] want,
                                         input logic [ADDR_W-1:0] got);
    if (!v)            return RES_IDLE;
    else if (want == got) return RES_HIT;
    else               return RES_MISS;
  endfunction

  always_comb begin
    eff_taken   = jump | taken;
    actual_next = eff_taken ? target : seq_addr(pc);
    kind        = classify(valid, actual_next, pred_next);
  end
endmodule

// File: rtl/brf_update.sv
module brf_update #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              valid,
  input  logic              jump,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pc,
  input  logic [IDX_W-1:0]  hist_idx,
  output logic              hist_upd_en,
  output logic              hist_upd_bit,
  output logic              pht_upd_en,
  output logic [IDX_W-1:0]  pht_upd_idx,
  output logic              pht_upd_taken,
  output logic              btb_upd_en,
  output logic [ADDR_W-1:0] btb_upd_pc,
  output logic [ADDR_W-1:0] btb_upd_target
);
  logic cond_br;

  always_comb begin
    cond_br        = valid & ~jump;
    hist_upd_en    = cond_br;
    hist_upd_bit   = cond_br & taken;
    pht_upd_en     = cond_br;
    pht_upd_idx    = cond_br ? hist_idx : '0;
    pht_upd_taken  = cond_br & taken;
    btb_upd_en     = valid;
    btb_upd_pc     = valid ? pc : '0;
    btb_upd_target = valid ? target : '0;
  end
endmodule

// File: rtl/brf_counter.sv
module brf_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + ONE;
  end
endmodule

// File: rtl/brf_unit.sv
module brf_unit
  import brf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_valid,
  input  logic              ex_jump,
  input  logic              ex_taken,
  input  logic [ADDR_W-1:0] ex_target,
  input  logic [ADDR_W-1:0] ex_pc,
  input  logic [ADDR_W-1:0] ex_pred_next,
  input  logic [IDX_W-1:0]  ex_hist_idx,
  output logic              flush,
  output logic              hist_upd_en,
  output logic              hist_upd_bit,
  output logic              pht_upd_en,
  output logic [IDX_W-1:0]  pht_upd_idx,
  output logic              pht_upd_taken,
  output logic              btb_upd_en,
  output logic [ADDR_W-1:0] btb_upd_pc,
  output logic [ADDR_W-1:0] btb_upd_target,
  output logic [CNT_W-1:0]  perf_total,
  output logic [CNT_W-1:0]  perf_correct
);
  logic              res_eff_taken;
  logic [ADDR_W-1:0] res_actual_next;
  res_kind_e         res_kind;
  logic              ev_hit;
  logic              ev_miss;
  logic [N_CNT-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_val [N_CNT];

  brf_resolve #(.ADDR_W(ADDR_W)) u_resolve (
    .valid       (ex_valid),
    .jump        (ex_jump),
    .taken       (ex_taken),
    .target      (ex_target),
    .pc          (ex_pc),
    .pred_next   (ex_pred_next),
    .eff_taken   (res_eff_taken),
    .actual_next (res_actual_next),
    .kind        (res_kind)
  );

  assign ev_hit  = (res_kind == RES_HIT);
  assign ev_miss = (res_kind == RES_MISS);
  assign flush   = ev_miss;

  brf_update #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_update (
    .valid          (ex_valid),
    .jump           (ex_jump),
    .taken          (ex_taken),
    .target         (ex_target),
    .pc             (ex_pc),
    .hist_idx       (ex_hist_idx),
    .hist_upd_en    (hist_upd_en),
    .hist_upd_bit   (hist_upd_bit),
    .pht_upd_en     (pht_upd_en),
    .pht_upd_idx    (pht_upd_idx),
    .pht_upd_taken  (pht_upd_taken),
    .btb_upd_en     (btb_upd_en),
    .btb_upd_pc     (btb_upd_pc),
    .btb_upd_target (btb_upd_target)
  );

  assign cnt_inc[CNT_TOTAL] = ev_hit | ev_miss;
  assign cnt_inc[CNT_GOOD]  = ev_hit;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    brf_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign perf_total   = cnt_val[CNT_TOTAL];
  assign perf_correct = cnt_val[CNT_GOOD];

  // R1: a taken transfer that fetched something other than its target flushes
  a_r1_taken_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && (ex_jump || ex_taken) && ex_pred_next != ex_target) |-> flush);
  // R2: a fall-through that fetched something other than pc+4 flushes
  a_r2_fall_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !ex_jump && !ex_taken && ex_pred_next != ex_pc + ADDR_W'(INSN_BYTES)) |-> flush);
  // R3: a correct fetch raises no flush
  a_r3_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_pred_next == res_actual_next) |-> !flush);
  // R4: empty slots are silent
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |-> (!flush && !btb_upd_en && !pht_upd_en && !hist_upd_en));
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> ($stable(perf_total) && $stable(perf_correct)));
  // R5: total steps by one per valid slot
  a_r5_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> perf_total == $past(perf_total) + 1'b1);
  // R6: correct count follows the absence of a flush
  a_r6_good_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && !flush) |=> perf_correct == $past(perf_correct) + 1'b1);
  a_r6_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> $stable(perf_correct));
  // R7: jumps do not train direction state
  a_r7_jump_no_train: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_jump) |-> (!pht_upd_en && !hist_upd_en && btb_upd_en));
  // R9: the same-cycle strobes agree with the resolved direction
  a_r9_dir_match: assert property (@(posedge clk) disable iff (!rst_n)
    pht_upd_en |-> (pht_upd_taken == res_eff_taken && hist_upd_bit == res_eff_taken));
  // R10: counters leave reset at zero
  a_r10_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (perf_total == '0 && perf_correct == '0));
endmodule

// File: tb/brf_unit_tb.sv
module brf_unit_tb;
  localparam int unsigned AW = 32;
  localparam int unsigned IW = 8;
  localparam int unsigned CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ex_valid, ex_jump, ex_taken;
  logic [AW-1:0] ex_target, ex_pc, ex_pred_next;
  logic [IW-1:0] ex_hist_idx;
  logic          flush, hist_upd_en, hist_upd_bit, pht_upd_en, pht_upd_taken, btb_upd_en;
  logic [IW-1:0] pht_upd_idx;
  logic [AW-1:0] btb_upd_pc, btb_upd_target;
  logic [CW-1:0] perf_total, perf_correct;

  int checks = 0;
  int errors = 0;
  longint exp_total = 0;
  longint exp_good  = 0;

  always #4 clk = ~clk;

  brf_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_jump(ex_jump),
    .ex_taken(ex_taken), .ex_target(ex_target), .ex_pc(ex_pc),
    .ex_pred_next(ex_pred_next), .ex_hist_idx(ex_hist_idx), .flush(flush),
    .hist_upd_en(hist_upd_en), .hist_upd_bit(hist_upd_bit),
    .pht_upd_en(pht_upd_en), .pht_upd_idx(pht_upd_idx),
    .pht_upd_taken(pht_upd_taken), .btb_upd_en(btb_upd_en),
    .btb_upd_pc(btb_upd_pc), .btb_upd_target(btb_upd_target),
    .perf_total(perf_total), .perf_correct(perf_correct)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_counters(input string req);
    check({req, " total"}, longint'(perf_total), exp_total);
    check({req, " correct"}, longint'(perf_correct), exp_good);
  endtask

  // one resolve slot: drive on falling edge, check combinational outputs 1 ns later
  task automatic slot(input logic v, input logic j, input logic t,
                      input logic [AW-1:0] pc, input logic [AW-1:0] tgt,
                      input logic [AW-1:0] pred, input logic [IW-1:0] idx);
    logic          eff;
    logic [AW-1:0] nxt;
    logic          exp_flush;
    @(negedge clk);
    check_counters("R5/R6");
    ex_valid = v; ex_jump = j; ex_taken = t;
    ex_pc = pc; ex_target = tgt; ex_pred_next = pred; ex_hist_idx = idx;
    #1;
    eff       = j || t;
    nxt       = eff ? tgt : pc + 32'd4;
    exp_flush = v && (pred != nxt);
    if (!v)           check("R4 flush idle", longint'(flush), 0);
    else if (exp_flush && eff)  check("R1 flush", longint'(flush), 1);
    else if (exp_flush)         check("R2 flush", longint'(flush), 1);
    else              check("R3 no flush", longint'(flush), 0);
    check("R8 btb en", longint'(btb_upd_en), longint'(v));
    if (v) begin
      check("R8 btb pc", longint'(btb_upd_pc), longint'(pc));
      check("R8 btb target", longint'(btb_upd_target), longint'(tgt));
    end
    check("R7 R9 pht en", longint'(pht_upd_en), longint'(v && !j));
    check("R7 R9 hist en", longint'(hist_upd_en), longint'(v && !j));
    if (v && !j) begin
      check("R9 pht idx", longint'(pht_upd_idx), longint'(idx));
      check("R9 pht dir", longint'(pht_upd_taken), longint'(t));
      check("R9 hist bit", longint'(hist_upd_bit), longint'(t));
    end
    if (v) exp_total = (exp_total + 1) % (64'd1 << CW);
    if (v && !exp_flush) exp_good = (exp_good + 1) % (64'd1 << CW);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] pc, tgt, pred;
    rst_n = 1'b0; ex_valid = 0; ex_jump = 0; ex_taken = 0;
    ex_pc = '0; ex_target = '0; ex_pred_next = '0; ex_hist_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_counters("R10 reset");
    rst_n = 1'b1;
    for (int tc = 0; tc < 3; tc++) begin
      pc  = 32'h0000_1000 + 32'(tc) * 32'h40;
      tgt = (tc == 1) ? pc + 32'd4 : 32'h0000_2000 - 32'(tc) * 32'h100;
      for (int v = 0; v < 2; v++)
        for (int j = 0; j < 2; j++)
          for (int t = 0; t < 2; t++)
            for (int p = 0; p < 3; p++) begin
              pred = (p == 0) ? tgt : (p == 1) ? pc + 32'd4 : 32'hDEAD_BEE0;
              slot(v[0], j[0], t[0], pc, tgt, pred, pc[9:2] ^ IW'(p * 37 + t));
            end
    end
    // back-to-back valid slots with mixed results
    for (int k = 0; k < 20; k++)
      slot(1'b1, k[0] & k[1], k[2], 32'h0000_4000 + 32'(k) * 4, 32'h0000_5000,
           (k % 3 == 0) ? 32'h0000_5000 : 32'h0000_4004 + 32'(k) * 4, IW'(k));
    slot(1'b0, 1'b0, 1'b0, '0, '0, '0, '0);
    @(negedge clk);
    check_counters("R5/R6 final");
    ex_valid = 0;
    rst_n = 1'b0;
    @(negedge clk);
    exp_total = 0; exp_good = 0;
    check_counters("R10 mid-run reset");
    rst_n = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule